// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is the bus-master data mover of a storage card host. Software builds a table of 64-bit descriptors in memory, loads the table's start address, chooses a direction and pulses `start`. The engine reads each descriptor through a single-beat memory port. It follows link descriptors to other tables, and for transfer descriptors it moves 32-bit words between memory and the card-side data FIFO. It stops after the descriptor marked as the end of the table.

A finished table is reported by a one-cycle `xfer_done`. A faulty descriptor is reported by a one-cycle `dma_err`, and no completion is reported for it. A descriptor can also ask for a one-cycle `desc_irq` when it retires. A data-line reset (`dline_reset`) abandons whatever the engine is doing.

The memory port is single-beat. A request (`mem_req` with address, write enable and write data) stays up, unchanged, until `mem_ready` is seen high at a clock edge. Read data is taken in that same cycle. The FIFO sides use valid/ready. A word moves on an edge where both are high. A sender must hold valid and data steady until the word is accepted. The engine holds `out_valid` and `out_data` while `out_ready` is low. On the write path `in_ready` follows `mem_ready` directly, so a word from the FIFO goes straight to memory with no buffering.

Top module: `sgdma_engine`

## Requirements
- R1: A descriptor is two 32-bit words at byte addresses P and P+4. The first word holds the attribute in bits 7:0, reserved bits in 15:8 and the byte length in 31:16. The second word holds the 32-bit address. Unless a link redirects the engine, the next descriptor is read from P+8.
- R2: A valid descriptor whose attribute bits 5:4 equal binary 10 moves len/4 words (rounded up) at consecutive word addresses starting from its address field. No memory word outside that range is written.
- R3: When `dir_to_mem` is 1, words taken from the input FIFO are written to memory in arrival order. When it is 0, memory words are read in address order and presented on the output FIFO. The direction is latched at `start`, and only one FIFO side is ever active at a time.
- R4: A valid descriptor with attribute bits 5:4 equal to binary 11 moves no data, and the next descriptor is read from its address field.
- R5: After the descriptor with attribute bit 1 (end) set has been fully processed, `xfer_done` is high for exactly one cycle, in the cycle where `busy` has already dropped.
- R6: A descriptor with attribute bit 0 (valid) clear causes a one-cycle `dma_err`, no data movement for it, no `xfer_done`, and a return to idle.
- R7: A valid descriptor whose action is binary 00 or 01, or a transfer descriptor whose length exceeds 63488 bytes, is handled exactly as in R6, before any of its data moves.
- R8: A transfer descriptor with length 0 makes no data access, and processing continues with the next descriptor.
- R9: When a descriptor with attribute bit 2 set retires (its data moved, or its link taken), `desc_irq` is high for one cycle.
- R10: When `dline_reset` is high at a clock edge, the next cycle shows `busy`, `mem_req`, `in_ready` and `out_valid` low. No `xfer_done` follows for the abandoned table.
- R11: A memory request that is not yet accepted keeps its address, write enable and write data in the next cycle. An output word that is not accepted keeps `out_valid` and `out_data`.
- R12: A `start` pulse while `busy` is high has no effect on the running table.
- R13: While idle, the engine issues no memory request and shows neither `in_ready` nor `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only when idle |
| dir_to_mem | input | 1 | 1: FIFO to memory, 0: memory to FIFO |
| tbl_base | input | AW | Byte address of the first descriptor |
| dline_reset | input | 1 | Data-line reset: abandon and go idle |
| busy | output | 1 | Engine is processing a table |
| xfer_done | output | 1 | One-cycle table-complete pulse |
| dma_err | output | 1 | One-cycle descriptor-fault pulse |
| desc_irq | output | 1 | One-cycle pulse when a descriptor with the interrupt bit retires |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| in_valid | input | 1 | Input FIFO word available |
| in_ready | output | 1 | Engine takes the input word |
| in_data | input | 32 | Input FIFO word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Output FIFO takes the word |
| out_data | output | 32 | Output word |

## Verification
The hold properties assume that the input FIFO never withdraws `in_valid` or changes `in_data` before the word is accepted. On the write path the memory request mirrors that source, so this assumption matters there. They also assume that memory answers each request with a single `mem_ready` beat and keeps `mem_rdata` valid in that cycle. The bench source advances its pattern index only on an accepted word, and it re-draws `in_valid` only after a handshake or while low. The memory model returns data combinationally for the addressed word. All descriptor lengths used are whole words, and the tables built by the bench never reach beyond the modelled memory.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int DW        = 32;
  localparam int LEN_W     = 16;
  localparam int WCNT_W    = LEN_W - 1;
  localparam int A_VALID   = 0;
  localparam int A_LAST    = 1;
  localparam int A_IRQ     = 2;
  localparam logic [1:0] ACT_XFER = 2'b10;
  localparam logic [1:0] ACT_LINK = 2'b11;

  typedef struct packed {
    logic [31:0]      addr;
    logic [LEN_W-1:0] len;
    logic [7:0]       rsvd;
    logic [7:0]       attr;
  } desc_t;

  typedef enum logic [1:0] {K_BAD, K_XFER, K_LINK, K_SKIP} kind_t;
  typedef enum logic [2:0] {C_IDLE, C_FLO, C_FHI, C_EXEC, C_MOVE} cstate_t;
  typedef enum logic [1:0] {M_IDLE, M_WR, M_RD, M_PUSH} mstate_t;
endpackage

// File: rtl/sgdma_desc_check.sv
module sgdma_desc_check
  import sgdma_pkg::*;
#(
  parameter int MAX_LEN = 63488
) (
  input  desc_t              d,
  output kind_t              kind,
  output logic               last,
  output logic               want_irq,
  output logic [WCNT_W-1:0]  words
);
  logic [1:0]     act;
  logic [LEN_W:0] len_up;
  logic           unused_bits;

  assign act         = d.attr[5:4];
  assign last        = d.attr[A_LAST];
  assign want_irq    = d.attr[A_IRQ];
  assign len_up      = {1'b0, d.len} + (LEN_W+1)'(3);
  assign words       = len_up[LEN_W:2];
  assign unused_bits = ^{d.rsvd, d.attr[7:6], d.attr[3]};

  always_comb begin
    if (!d.attr[A_VALID]) begin
      kind = K_BAD;
    end else if (act == ACT_LINK) begin
      kind = K_LINK;
    end else if (act == ACT_XFER) begin
      if (32'(d.len) > 32'(MAX_LEN))  kind = K_BAD;
      else if (d.len == '0)           kind = K_SKIP;
      else                            kind = K_XFER;
    end else begin
      kind = K_BAD;
    end
  end
endmodule

// File: rtl/sgdma_mover.sv
module sgdma_mover
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              go,
  input  logic              to_mem,
  input  logic [AW-1:0]     start_addr,
  input  logic [WCNT_W-1:0] words,
  output logic              fin,
  output logic              active,
  output logic              m_req,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  input  logic              out_ready
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  mstate_t           st_q;
  logic [AW-1:0]     addr_q;
  logic [WCNT_W-1:0] left_q;
  logic [DW-1:0]     hold_q;
  logic              beat;

  always_comb begin
    m_req     = 1'b0;
    m_we      = 1'b0;
    m_wdata   = '0;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    beat      = 1'b0;
    unique case (st_q)
      M_WR: begin
        m_req    = in_valid;
        m_we     = 1'b1;
        m_wdata  = in_data;
        in_ready = m_ready;
        beat     = in_valid && m_ready;
      end
      M_RD:   m_req = 1'b1;
      M_PUSH: begin
        out_valid = 1'b1;
        beat      = out_ready;
      end
      default: ;
    endcase
  end

  assign fin      = beat && (left_q == WCNT_W'(1));
  assign active   = (st_q != M_IDLE);
  assign m_addr   = addr_q;
  assign out_data = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      addr_q <= '0;
      left_q <= '0;
      hold_q <= '0;
    end else if (abort) begin
      st_q <= M_IDLE;
    end else begin
      unique case (st_q)
        M_IDLE: if (go) begin
          addr_q <= start_addr;
          left_q <= words;
          st_q   <= to_mem ? M_WR : M_RD;
        end
        M_WR: if (beat) begin
          addr_q <= addr_q + STEP;
          left_q <= left_q - WCNT_W'(1);
          if (fin) st_q <= M_IDLE;
        end
        M_RD: if (m_ready) begin
          hold_q <= m_rdata;
          st_q   <= M_PUSH;
        end
        M_PUSH: if (beat) begin
          addr_q <= addr_q + STEP;
          left_q <= left_q - WCNT_W'(1);
          st_q   <= fin ? M_IDLE : M_RD;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 63488
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic              dir_in,
  output logic              busy,
  output logic              done_p,
  output logic              err_p,
  output logic              irq_p,
  output logic              f_req,
  output logic [AW-1:0]     f_addr,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata,
  output logic              mv_go,
  output logic              mv_dir,
  output logic [AW-1:0]     mv_addr,
  output logic [WCNT_W-1:0] mv_words,
  input  logic              mv_fin
);
  localparam logic [AW-1:0] HI_OFS   = AW'(4);
  localparam logic [AW-1:0] DESC_OFS = AW'(8);

  cstate_t       st_q;
  logic [AW-1:0] ptr_q;
  desc_t         desc_q;
  logic          dir_q;
  kind_t         kind;
  logic          last;
  logic          want_irq;
  logic          retire;
  logic [AW-1:0] nxt_ptr;

  sgdma_desc_check #(.MAX_LEN(MAX_LEN)) u_check (
    .d        (desc_q),
    .kind     (kind),
    .last     (last),
    .want_irq (want_irq),
    .words    (mv_words)
  );

  assign busy    = (st_q != C_IDLE);
  assign f_req   = (st_q == C_FLO) || (st_q == C_FHI);
  assign f_addr  = (st_q == C_FHI) ? ptr_q + HI_OFS : ptr_q;
  assign mv_go   = (st_q == C_EXEC) && (kind == K_XFER);
  assign mv_dir  = dir_q;
  assign mv_addr = desc_q.addr[AW-1:0];
  assign retire  = ((st_q == C_EXEC) && ((kind == K_LINK) || (kind == K_SKIP))) ||
                   ((st_q == C_MOVE) && mv_fin);
  assign nxt_ptr = (kind == K_LINK) ? desc_q.addr[AW-1:0] : ptr_q + DESC_OFS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      ptr_q  <= '0;
      desc_q <= '0;
      dir_q  <= 1'b0;
      done_p <= 1'b0;
      err_p  <= 1'b0;
      irq_p  <= 1'b0;
    end else begin
      done_p <= 1'b0;
      err_p  <= 1'b0;
      irq_p  <= 1'b0;
      if (abort) begin
        st_q <= C_IDLE;
      end else begin
        unique case (st_q)
          C_IDLE: if (start) begin
            ptr_q <= base;
            dir_q <= dir_in;
            st_q  <= C_FLO;
          end
          C_FLO: if (m_ready) begin
            desc_q[31:0] <= m_rdata;
            st_q         <= C_FHI;
          end
          C_FHI: if (m_ready) begin
            desc_q[63:32] <= m_rdata;
            st_q          <= C_EXEC;
          end
          C_EXEC: begin
            if (kind == K_BAD) begin
              err_p <= 1'b1;
              st_q  <= C_IDLE;
            end else if (kind == K_XFER) begin
              st_q <= C_MOVE;
            end
          end
          default: ;
        endcase
        if (retire) begin
          irq_p <= want_irq;
          if (last) begin
            done_p <= 1'b1;
            st_q   <= C_IDLE;
          end else begin
            ptr_q <= nxt_ptr;
            st_q  <= C_FLO;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 63488
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_to_mem,
  input  logic [AW-1:0] tbl_base,
  input  logic          dline_reset,
  output logic          busy,
  output logic          xfer_done,
  output logic          dma_err,
  output logic          desc_irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data
);
  logic              f_req;
  logic [AW-1:0]     f_addr;
  logic              mv_go;
  logic              mv_dir;
  logic [AW-1:0]     mv_start;
  logic [WCNT_W-1:0] mv_words;
  logic              mv_fin;
  logic              mv_active;
  logic              mv_req;
  logic              mv_we;
  logic [AW-1:0]     mv_addr;
  logic [DW-1:0]     mv_wdata;

  sgdma_ctrl #(.AW(AW), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (dline_reset),
    .start    (start),
    .base     (tbl_base),
    .dir_in   (dir_to_mem),
    .busy     (busy),
    .done_p   (xfer_done),
    .err_p    (dma_err),
    .irq_p    (desc_irq),
    .f_req    (f_req),
    .f_addr   (f_addr),
    .m_ready  (mem_ready),
    .m_rdata  (mem_rdata),
    .mv_go    (mv_go),
    .mv_dir   (mv_dir),
    .mv_addr  (mv_start),
    .mv_words (mv_words),
    .mv_fin   (mv_fin)
  );

  sgdma_mover #(.AW(AW)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (dline_reset),
    .go         (mv_go),
    .to_mem     (mv_dir),
    .start_addr (mv_start),
    .words      (mv_words),
    .fin        (mv_fin),
    .active     (mv_active),
    .m_req      (mv_req),
    .m_we       (mv_we),
    .m_addr     (mv_addr),
    .m_wdata    (mv_wdata),
    .m_ready    (mem_ready),
    .m_rdata    (mem_rdata),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready)
  );

  assign mem_req   = mv_active ? mv_req  : f_req;
  assign mem_we    = mv_active & mv_we;
  assign mem_addr  = mv_active ? mv_addr : f_addr;
  assign mem_wdata = mv_wdata;
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dline_reset,
  input logic          busy,
  input logic          xfer_done,
  input logic          dma_err,
  input logic          desc_irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || dline_reset)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || dline_reset)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  p_err_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err |-> !busy && !xfer_done);

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_irq |=> !desc_irq);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dline_reset |=> !busy && !mem_req && !in_ready && !out_valid);

  p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !in_ready && !out_valid);
endmodule

bind sgdma_engine sgdma_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/sgdma_engine_tb.sv
module sgdma_engine_tb;
  localparam int AW = 32;
  localparam logic [7:0] AV = 8'h01, AE = 8'h02, AI = 8'h04;
  localparam logic [7:0] AXF = 8'h20, ALK = 8'h30;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_to_mem = 1'b0, dline_reset = 1'b0;
  logic [AW-1:0] tbl_base = '0;
  logic busy, xfer_done, dma_err, desc_irq;
  logic mem_req, mem_we, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, in_data, out_data;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;

  always #5 clk = ~clk;

  sgdma_engine #(.AW(AW)) u_dut (.*);

  logic [31:0] mem [0:4095];
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  logic        src_en = 1'b0, src_clr = 1'b0, sink_clr = 1'b0, acc = 1'b0;
  int unsigned src_idx = 0, sink_n = 0;
  logic [31:0] sink [0:511];
  int unsigned done_cnt = 0, err_cnt = 0, irq_cnt = 0;
  int n_chk = 0, n_fail = 0;

  function automatic logic [31:0] pat(int unsigned k);
    return 32'hC0DE_0000 ^ (k * 32'h0001_9E37);
  endfunction
  function automatic logic [31:0] memval(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign mem_rdata = mem[mem_addr[13:2]];
  assign in_data   = pat(src_idx);

  always @(posedge clk) begin
    if (bw_en) mem[bw_addr[13:2]] <= bw_data;
    else if (mem_req && mem_ready && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    acc <= in_valid && in_ready;
    if (src_clr) src_idx <= 0;
    else if (in_valid && in_ready) src_idx <= src_idx + 1;
    if (sink_clr) sink_n <= 0;
    else if (out_valid && out_ready) begin
      sink[sink_n[8:0]] <= out_data;
      sink_n <= sink_n + 1;
    end
    if (xfer_done) done_cnt <= done_cnt + 1;
    if (dma_err)   err_cnt  <= err_cnt + 1;
    if (desc_irq)  irq_cnt  <= irq_cnt + 1;
  end

  always @(negedge clk) begin
    mem_ready <= ($urandom % 4) != 0;
    out_ready <= ($urandom % 3) != 0;
    if (!src_en) in_valid <= 1'b0;
    else if (acc || !in_valid) in_valid <= ($urandom % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] p, input logic [7:0] attr,
                          input logic [15:0] len, input logic [31:0] a);
    wr(p, {len, 8'h00, attr});
    wr(p + 4, a);
  endtask

  task automatic clear_streams();
    src_clr = 1'b1; sink_clr = 1'b1;
    @(negedge clk);
    src_clr = 1'b0; sink_clr = 1'b0;
  endtask

  task automatic kick(input logic [31:0] base, input logic d2m);
    src_en = d2m;
    tbl_base = base; dir_to_mem = d2m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input int unsigned d0, input int unsigned e0);
    for (int i = 0; i < 20000; i++) begin
      if (done_cnt != d0 || err_cnt != e0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    src_en = 1'b0;
  endtask

  logic [31:0] exp_a [0:63];
  logic [31:0] exp_v [0:63];
  int          exp_n, exp_irq;

  task automatic random_run(input int it, input logic d2m);
    logic [31:0] tp, t0, db;
    int nd, w;
    int unsigned d0, e0, i0;
    logic [7:0] attr;
    tp = 32'h800 + it * 32'h100; t0 = tp;
    db = d2m ? 32'h3400 + it * 32'h100 : 32'h1000 + it * 32'h200;
    nd = 1 + $urandom % 4; exp_n = 0; exp_irq = 0;
    for (int i = 0; i < nd; i++) begin
      if ($urandom % 3 == 0) begin
        put_desc(tp, AV | ALK, 16'd0, tp + 32'h40);
        tp = tp + 32'h40;
      end
      w = $urandom % 6;
      attr = AV | AXF | ((i == nd - 1) ? AE : 8'h00) | (($urandom % 2) ? AI : 8'h00);
      if (attr[2]) exp_irq++;
      put_desc(tp, attr, 16'(w * 4), db);
      for (int j = 0; j <= w; j++) if (d2m) wr(db + 4 * j, SENT);
      for (int j = 0; j < w; j++) begin
        exp_a[exp_n] = db + 4 * j;
        exp_v[exp_n] = d2m ? pat(exp_n) : memval(db + 4 * j);
        exp_n++;
      end
      db = db + w * 4 + 4;
      tp = tp + 8;
    end
    clear_streams();
    d0 = done_cnt; e0 = err_cnt; i0 = irq_cnt;
    kick(t0, d2m);
    wait_end(d0, e0);
    chk(done_cnt == d0 + 1, "R5", done_cnt - d0, 1);
    chk(err_cnt == e0, "R6", err_cnt - e0, 0);
    chk(irq_cnt - i0 == exp_irq, "R9", irq_cnt - i0, exp_irq);
    if (d2m) begin
      for (int k = 0; k < exp_n; k++)
        chk(mem[exp_a[k][13:2]] == exp_v[k], "R3", mem[exp_a[k][13:2]], exp_v[k]);
      chk(mem[db[13:2] - 1] == SENT, "R2", mem[db[13:2] - 1], SENT);
    end else begin
      chk(sink_n == exp_n, "R3", sink_n, exp_n);
      for (int k = 0; k < exp_n; k++)
        chk(sink[k] == exp_v[k], "R4", sink[k], exp_v[k]);
    end
  endtask

  task automatic run_all();
    int unsigned d0, e0, i0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !xfer_done && !dma_err && !in_ready && !out_valid,
        "R13", {busy, mem_req, xfer_done, dma_err, in_ready, out_valid}, 0);
    rst_n = 1'b1;
    for (int a = 32'h1000; a < 32'h2000; a += 4) wr(a, memval(a));

    // R1 R2 R3: single descriptor FIFO to memory
    for (int k = 0; k < 5; k++) wr(32'h3000 + 4 * k, SENT);
    put_desc(32'h000, AV | AE | AXF, 16'd16, 32'h3000);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h000, 1'b1); wait_end(d0, e0);
    chk(done_cnt == d0 + 1, "R5", done_cnt - d0, 1);
    for (int k = 0; k < 4; k++)
      chk(mem[(32'h3000 >> 2) + k] == pat(k), "R2", mem[(32'h3000 >> 2) + k], pat(k));
    chk(mem[(32'h3010 >> 2)] == SENT, "R2", mem[(32'h3010 >> 2)], SENT);

    // R4 R1 R9: memory to FIFO across a link
    put_desc(32'h100, AV | AI | AXF, 16'd8, 32'h1C00);
    put_desc(32'h108, AV | ALK, 16'd0, 32'h300);
    put_desc(32'h300, AV | AE | AXF, 16'd12, 32'h1D00);
    clear_streams(); d0 = done_cnt; e0 = err_cnt; i0 = irq_cnt;
    kick(32'h100, 1'b0); wait_end(d0, e0);
    chk(done_cnt == d0 + 1, "R4", done_cnt - d0, 1);
    chk(irq_cnt == i0 + 1, "R9", irq_cnt - i0, 1);
    chk(sink_n == 5, "R4", sink_n, 5);
    chk(sink[0] == memval(32'h1C00) && sink[1] == memval(32'h1C04), "R1", sink[1], memval(32'h1C04));
    chk(sink[2] == memval(32'h1D00) && sink[4] == memval(32'h1D08), "R4", sink[4], memval(32'h1D08));

    // R6: valid bit clear
    wr(32'h3100, SENT); wr(32'h3104, SENT);
    put_desc(32'h400, AV | AXF, 16'd4, 32'h3100);
    put_desc(32'h408, AXF | AE, 16'd4, 32'h3104);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h400, 1'b1); wait_end(d0, e0);
    chk(err_cnt == e0 + 1, "R6", err_cnt - e0, 1);
    chk(done_cnt == d0, "R6", done_cnt - d0, 0);
    chk(mem[32'h3100 >> 2] == pat(0), "R6", mem[32'h3100 >> 2], pat(0));
    chk(mem[32'h3104 >> 2] == SENT, "R6", mem[32'h3104 >> 2], SENT);

    // R7: reserved action, then oversize length
    put_desc(32'h620, AV | AE | 8'h10, 16'd8, 32'h1000);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h620, 1'b0); wait_end(d0, e0);
    chk(err_cnt == e0 + 1 && done_cnt == d0, "R7", err_cnt - e0, 1);
    chk(sink_n == 0, "R7", sink_n, 0);
    put_desc(32'h640, AV | AE | AXF, 16'd63492, 32'h1000);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h640, 1'b0); wait_end(d0, e0);
    chk(err_cnt == e0 + 1 && done_cnt == d0, "R7", err_cnt - e0, 1);
    chk(sink_n == 0, "R7", sink_n, 0);

    // R8: zero length then one word
    wr(32'h3200, SENT); wr(32'h3204, SENT);
    put_desc(32'h680, AV | AXF, 16'd0, 32'h3200);
    put_desc(32'h688, AV | AE | AXF, 16'd4, 32'h3204);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h680, 1'b1); wait_end(d0, e0);
    chk(done_cnt == d0 + 1, "R8", done_cnt - d0, 1);
    chk(mem[32'h3200 >> 2] == SENT, "R8", mem[32'h3200 >> 2], SENT);
    chk(mem[32'h3204 >> 2] == pat(0), "R8", mem[32'h3204 >> 2], pat(0));

    // R10: abort in the middle of a long read
    put_desc(32'h600, AV | AE | AXF, 16'd400, 32'h1000);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h600, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy, "R10", busy, 1);
    dline_reset = 1'b1;
    @(negedge clk);
    dline_reset = 1'b0;
    chk(!busy && !mem_req && !out_valid && !in_ready, "R10",
        {busy, mem_req, out_valid, in_ready}, 0);
    repeat (100) @(negedge clk);
    chk(done_cnt == d0 && err_cnt == e0, "R10", done_cnt - d0, 0);

    // R12: start while busy is ignored
    for (int k = 0; k < 9; k++) wr(32'h3300 + 4 * k, SENT);
    put_desc(32'h6C0, AV | AE | AXF, 16'd32, 32'h3300);
    clear_streams(); d0 = done_cnt; e0 = err_cnt;
    kick(32'h6C0, 1'b1);
    repeat (4) @(negedge clk);
    tbl_base = 32'h408; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end(d0, e0);
    chk(done_cnt == d0 + 1 && err_cnt == e0, "R12", err_cnt - e0, 0);
    chk(mem[(32'h3300 >> 2) + 7] == pat(7), "R12", mem[(32'h3300 >> 2) + 7], pat(7));
    chk(mem[(32'h3300 >> 2) + 8] == SENT, "R2", mem[(32'h3300 >> 2) + 8], SENT);

    for (int it = 0; it < 6; it++) random_run(it, ($urandom % 2) == 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule